// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Grid Scanner with Dimming

This block scans a multiplexed vacuum fluorescent display with up to 16 grids and 24 segments. It lights one grid at a time. For every grid slot it reads that grid's three segment bytes from a synchronous display memory, with a read latency of one cycle. It then drives the segment enables together with the single grid enable. The enables stay on for only part of each slot, so the share of the slot that is lit sets the brightness. The display turns dark at once when the scan length is reprogrammed, and it stays dark until a display-on command arrives.

A command decoder outside the block supplies the scan-length code, the brightness code and the on/off flag. The scan-length code comes with a `len_wr` strobe, and the brightness code and on/off flag come with a `ctl_wr` strobe. A new scan length or brightness waits and takes effect only when the current scan cycle ends. The block raises a one-cycle pulse on `scan_end` in the last clock of each cycle. The scan keeps running while the display is dark, so a key matrix that shares the scan timing keeps working.

The controller is a three-state machine that repeats once per grid slot:
- `ST_ADDR` puts the grid's first byte address on the memory port.
- `ST_LOAD` captures the returned bytes, one per cycle, and stays for three cycles.
- `ST_SHOW` lasts 16 ticks of `TICK_DIV` clocks each.

The transitions are ADDR→LOAD, LOAD→SHOW after the last byte, and SHOW→ADDR after the 16th tick.

Top module: `vfd_scan_mux`

## Requirements
- R1: Length code 4'b0000 scans grids 0..7, and length codes 4'b1000 to 4'b1111 scan 9 to 16 grids (count = 9 + low three bits). Grids are visited in ascending order, so one cycle lasts grids × (4 + 16·TICK_DIV) clocks.
- R2: A length code from 4'b0001 to 4'b0111 is ignored: the scan length and the on/off state stay as they were.
- R3: After reset, the block scans 16 grids with a brightness of 1/16 and the display off. All enables are 0 and the cycle is 16 × (4 + 16·TICK_DIV) clocks long.
- R4: Grid d reads memory addresses 3d, 3d+1 and 3d+2. The byte at 3d+k drives `seg_en[8k+7:8k]`: its low nibble goes to the lower four segments and its high nibble to the upper four.
- R5: Brightness codes 0 to 7 keep the enables on for the first 1, 2, 4, 10, 11, 12, 13 or 14 of the 16 ticks of the show phase.
- R6: A valid length code that differs from the last accepted one turns the display off from the next clock. It stays off until `ctl_wr` arrives with `disp_on` = 1.
- R7: A length code equal to the last accepted one changes nothing, and a lit display stays lit.
- R8: While the display is off, `grid_en` and `seg_en` are 0 while scan timing and `scan_end` carry on.
- R9: `scan_end` is high for exactly the last clock of the last grid slot. A new length or brightness is applied only at that edge.
- R10: At most one bit of `grid_en` is set. Both enables are 0 during the address and load phases and after the lit ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_code | input | 4 | Scan-length code |
| len_wr | input | 1 | One-cycle strobe that applies `len_code` |
| dim_code | input | 3 | Brightness code |
| disp_on | input | 1 | Display on (1) / off (0) |
| ctl_wr | input | 1 | One-cycle strobe that applies `dim_code` and `disp_on` |
| mem_addr | output | 6 | Display memory read address |
| mem_rdata | input | 8 | Read data, valid the clock after its address |
| grid_en | output | 16 | Grid enables, active high |
| seg_en | output | 24 | Segment enables, active high |
| scan_end | output | 1 | End-of-cycle pulse |

## Verification
The assertions assume that the memory returns the byte for an address in the clock after that address appears. They also assume that both command strobes last one cycle and are driven only from clean register outputs. The bench keeps to these assumptions. Its memory model is a registered array read at every posedge, and it rewrites the array only right after a `scan_end` pulse, so no fetch ever sees a byte change part-way through. The strobes are raised for exactly one clock, with the data and strobe driven on the falling edge.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    typedef enum logic [1:0] {
        ST_ADDR = 2'd0,
        ST_LOAD = 2'd1,
        ST_SHOW = 2'd2
    } scan_state_t;

    localparam int SLOT_TICKS = 16;

    // Accepted length codes: all zero, or MSB set.
    function automatic logic len_ok(input logic [3:0] code);
        return (code == 4'b0000) || code[3];
    endfunction

    function automatic logic [4:0] len_grids(input logic [3:0] code);
        return code[3] ? (5'd9 + {2'b00, code[2:0]}) : 5'd8;
    endfunction

    // Lit ticks out of SLOT_TICKS for each brightness code.
    function automatic logic [4:0] dim_ticks(input logic [2:0] code);
        logic [4:0] t;
        case (code)
            3'd0:    t = 5'd1;
            3'd1:    t = 5'd2;
            3'd2:    t = 5'd4;
            3'd3:    t = 5'd10;
            3'd4:    t = 5'd11;
            3'd5:    t = 5'd12;
            3'd6:    t = 5'd13;
            default: t = 5'd14;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/vfd_cfg.sv
module vfd_cfg
    import vfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] len_code,
    input  logic       len_wr,
    input  logic [2:0] dim_code,
    input  logic       disp_on,
    input  logic       ctl_wr,
    input  logic       frame_end,
    output logic [4:0] act_grids,
    output logic [4:0] act_ticks,
    output logic       lit_on
);

    logic [3:0] pend_len;
    logic [2:0] pend_dim;
    logic       len_take;

    assign len_take = len_wr && len_ok(len_code) && (len_code != pend_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_len  <= 4'b1111;
            pend_dim  <= 3'd0;
            lit_on    <= 1'b0;
            act_grids <= 5'd16;
            act_ticks <= 5'd1;
        end else begin
            if (len_take) begin
                pend_len <= len_code;
                lit_on   <= 1'b0;
            end else if (ctl_wr) begin
                lit_on   <= disp_on;
            end
            if (ctl_wr) begin
                pend_dim <= dim_code;
            end
            if (frame_end) begin
                act_grids <= len_grids(pend_len);
                act_ticks <= dim_ticks(pend_dim);
            end
        end
    end

    // R6
    len_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_wr && len_ok(len_code) && (len_code != pend_len)) |=> !lit_on);

    // R2
    bad_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_wr && !len_ok(len_code) && !ctl_wr) |=> ($stable(lit_on) && $stable(pend_len)));

    // R9
    grids_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(act_grids) && $stable(act_ticks)));

endmodule

// File: rtl/vfd_scan_fsm.sv
module vfd_scan_fsm
    import vfd_pkg::*;
#(
    parameter int GRIDS    = 16,
    parameter int SEGS     = 24,
    parameter int TICK_DIV = 4,
    localparam int BPD     = SEGS / 8,
    localparam int ADDR_W  = $clog2(GRIDS * BPD),
    localparam int DIG_W   = $clog2(GRIDS),
    localparam int TICK_W  = $clog2(SLOT_TICKS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        act_grids,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DIG_W-1:0]  digit,
    output logic              show,
    output logic [TICK_W-1:0] tick,
    output logic [SEGS-1:0]   seg_buf,
    output logic              frame_end
);

    localparam int IDX_W = (BPD > 1) ? $clog2(BPD) : 1;
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    scan_state_t state, state_nx;
    logic [IDX_W-1:0] idx;
    logic [DIV_W-1:0] div_cnt;
    logic             tick_last;
    logic             slot_done;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    assign tick_last = (div_cnt == DIV_W'(TICK_DIV - 1));
    assign slot_done = (state == ST_SHOW) && (tick == TICK_W'(SLOT_TICKS - 1)) && tick_last;
    assign frame_end = slot_done && ({1'b0, digit} == (act_grids - 5'd1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ADDR: state_nx = ST_LOAD;
            ST_LOAD: if (idx == IDX_W'(BPD - 1)) state_nx = ST_SHOW;
            ST_SHOW: if (slot_done) state_nx = ST_ADDR;
            default: state_nx = ST_ADDR;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ADDR;
        else        state <= state_nx;
    end

    // Slot counters and byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            div_cnt <= '0;
            tick    <= '0;
            digit   <= '0;
            seg_buf <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    idx     <= '0;
                    div_cnt <= '0;
                    tick    <= '0;
                end
                ST_LOAD: begin
                    seg_buf[idx*8 +: 8] <= mem_rdata;
                    idx <= idx + IDX_W'(1);
                end
                ST_SHOW: begin
                    if (tick_last) begin
                        div_cnt <= '0;
                        tick    <= tick + TICK_W'(1);
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                    if (slot_done) begin
                        digit <= frame_end ? '0 : digit + DIG_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        base = ADDR_W'(int'(digit) * BPD);
        offs = '0;
        if (state == ST_LOAD && idx != IDX_W'(BPD - 1)) begin
            offs = ADDR_W'(idx) + ADDR_W'(1);
        end
        mem_addr = base + offs;
        show     = (state == ST_SHOW);
    end

    // R9
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R4
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mem_addr) < GRIDS * BPD);

endmodule

// File: rtl/vfd_out_gate.sv
module vfd_out_gate
    import vfd_pkg::*;
#(
    parameter int GRIDS   = 16,
    parameter int SEGS    = 24,
    localparam int DIG_W  = $clog2(GRIDS),
    localparam int TICK_W = $clog2(SLOT_TICKS)
)(
    input  logic              lit_on,
    input  logic              show,
    input  logic [TICK_W-1:0] tick,
    input  logic [4:0]        act_ticks,
    input  logic [DIG_W-1:0]  digit,
    input  logic [SEGS-1:0]   seg_buf,
    output logic [GRIDS-1:0]  grid_en,
    output logic [SEGS-1:0]   seg_en
);

    logic lit;

    assign lit    = lit_on && show && (5'(tick) < act_ticks);
    assign seg_en = lit ? seg_buf : '0;

    for (genvar g = 0; g < GRIDS; g++) begin : g_grid
        assign grid_en[g] = lit && (digit == DIG_W'(g));
    end

endmodule

// File: rtl/vfd_scan_mux.sv
module vfd_scan_mux
    import vfd_pkg::*;
#(
    parameter int GRIDS    = 16,
    parameter int SEGS     = 24,
    parameter int TICK_DIV = 4,
    localparam int BPD     = SEGS / 8,
    localparam int ADDR_W  = $clog2(GRIDS * BPD),
    localparam int DIG_W   = $clog2(GRIDS),
    localparam int TICK_W  = $clog2(SLOT_TICKS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        len_code,
    input  logic              len_wr,
    input  logic [2:0]        dim_code,
    input  logic              disp_on,
    input  logic              ctl_wr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [GRIDS-1:0]  grid_en,
    output logic [SEGS-1:0]   seg_en,
    output logic              scan_end
);

    logic [4:0]        act_grids;
    logic [4:0]        act_ticks;
    logic              lit_on;
    logic [DIG_W-1:0]  digit;
    logic              show;
    logic [TICK_W-1:0] tick;
    logic [SEGS-1:0]   seg_buf;

    vfd_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_code  (len_code),
        .len_wr    (len_wr),
        .dim_code  (dim_code),
        .disp_on   (disp_on),
        .ctl_wr    (ctl_wr),
        .frame_end (scan_end),
        .act_grids (act_grids),
        .act_ticks (act_ticks),
        .lit_on    (lit_on)
    );

    vfd_scan_fsm #(.GRIDS(GRIDS), .SEGS(SEGS), .TICK_DIV(TICK_DIV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_grids (act_grids),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .digit     (digit),
        .show      (show),
        .tick      (tick),
        .seg_buf   (seg_buf),
        .frame_end (scan_end)
    );

    vfd_out_gate #(.GRIDS(GRIDS), .SEGS(SEGS)) u_gate (
        .lit_on    (lit_on),
        .show      (show),
        .tick      (tick),
        .act_ticks (act_ticks),
        .digit     (digit),
        .seg_buf   (seg_buf),
        .grid_en   (grid_en),
        .seg_en    (seg_en)
    );

    // R10
    one_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_en));

    // R8
    seg_needs_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en != '0) |-> (grid_en != '0));

endmodule

// File: tb/sim_vfd_scan_mux.sv
`timescale 1ns/1ps
module sim_vfd_scan_mux;

    localparam int TD   = 2;
    localparam int BPD  = 3;
    localparam int SLOT = 1 + BPD + 16 * TD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  len_code = 4'b0;
    logic        len_wr = 1'b0;
    logic [2:0]  dim_code = 3'd0;
    logic        disp_on = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [5:0]  mem_addr;
    logic [7:0]  mem_rdata;
    logic [15:0] grid_en;
    logic [23:0] seg_en;
    logic        scan_end;

    logic [7:0] mem [48];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference state
    int m_c, m_dig, m_nd, m_wid, m_pmode, m_pdim;
    bit m_on;
    logic [23:0] m_seg;

    always #4 clk = ~clk;

    vfd_scan_mux #(.TICK_DIV(TD)) u0 (
        .clk(clk), .rst_n(rst_n), .len_code(len_code), .len_wr(len_wr),
        .dim_code(dim_code), .disp_on(disp_on), .ctl_wr(ctl_wr),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .grid_en(grid_en),
        .seg_en(seg_en), .scan_end(scan_end)
    );

    always @(posedge clk) mem_rdata <= mem[mem_addr];

    function automatic int ref_grids(input int code);
        if (code == 0) return 8;
        return 9 + (code % 8);
    endfunction

    function automatic int ref_ticks(input int code);
        int tbl [8] = '{1, 2, 4, 10, 11, 12, 13, 14};
        return tbl[code];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // reference model advance
    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_dig = 0; m_nd = 16; m_wid = 1;
            m_pmode = 15; m_pdim = 0; m_on = 0; m_seg = '0;
        end else begin
            if (m_c == BPD) m_seg = {mem[3*m_dig+2], mem[3*m_dig+1], mem[3*m_dig]};
            if (m_c == SLOT - 1) begin
                m_c = 0;
                if (m_dig == m_nd - 1) begin
                    m_dig = 0;
                    m_nd  = ref_grids(m_pmode);
                    m_wid = ref_ticks(m_pdim);
                end else m_dig++;
            end else m_c++;
            if (ctl_wr) begin m_pdim = int'(dim_code); m_on = disp_on; end
            if (len_wr && (len_code == 4'b0 || len_code[3]) && int'(len_code) != m_pmode) begin
                m_pmode = int'(len_code);
                m_on = 0;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit lit;
            logic [15:0] eg;
            logic [23:0] es;
            bit ee;
            lit = m_on && (m_c > BPD) && (((m_c - BPD - 1) / TD) < m_wid);
            eg  = lit ? (16'd1 << m_dig) : 16'd0;
            es  = lit ? m_seg : 24'd0;
            ee  = (m_dig == m_nd - 1) && (m_c == SLOT - 1);
            check(grid_en == eg, "R1 R5 grid", grid_en, eg);
            check(seg_en == es, "R4 R5 segments", seg_en, es);
            check(scan_end == ee, "R9 scan_end", scan_end, ee);
            check($countones(grid_en) <= 1, "R10 one grid", grid_en, eg);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic send_ctl(input int d, input bit on);
        @(negedge clk);
        dim_code = 3'(d); disp_on = on; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic send_len(input logic [3:0] c);
        @(negedge clk);
        len_code = c; len_wr = 1'b1;
        @(negedge clk);
        len_wr = 1'b0;
    endtask

    task automatic wait_end();
        @(negedge clk);
        while (scan_end !== 1'b1) @(negedge clk);
    endtask

    // from one scan_end to the next: length and lit cycles
    task automatic measure(output int len, output int lit);
        len = 0; lit = 0;
        wait_end();
        do begin
            @(negedge clk);
            len++;
            if (grid_en != 0) lit++;
        end while (scan_end !== 1'b1);
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < 48; a++) mem[a] = 8'((a * 37 + seed) ^ (a << 3));
    endtask

    initial begin
        int len, lit;
        fill(5);
        repeat (3) @(negedge clk);
        // R3: enables low during reset
        check(grid_en == 0 && seg_en == 0 && scan_end == 0, "R3 reset outputs", {grid_en, seg_en}, 0);
        rst_n = 1'b1;

        // R3: 16-grid cycle, dark
        measure(len, lit);
        check(len == 16 * SLOT, "R3 default cycle length", len, 16 * SLOT);
        check(lit == 0, "R3 off after reset", lit, 0);

        // R5: each brightness code
        for (int d = 0; d < 8; d++) begin
            send_ctl(d, 1'b1);
            measure(len, lit);
            check(lit == 16 * ref_ticks(d) * TD, "R5 lit ticks", lit, 16 * ref_ticks(d) * TD);
        end

        // R4: new pattern, direct look at grid 5
        wait_end();
        fill(91);
        while (grid_en != 16'h0020) @(negedge clk);
        check(seg_en == {mem[17], mem[16], mem[15]}, "R4 grid 5 bytes", seg_en, {mem[17], mem[16], mem[15]});

        // R1: 8 grids
        send_len(4'b0000);
        send_ctl(7, 1'b1);
        measure(len, lit);
        check(len == 8 * SLOT, "R1 eight grids", len, 8 * SLOT);
        check(lit == 8 * 14 * TD, "R1 eight grids lit", lit, 8 * 14 * TD);

        // R1: 11 grids
        send_len(4'b1010);
        send_ctl(3, 1'b1);
        measure(len, lit);
        check(len == 11 * SLOT, "R1 eleven grids", len, 11 * SLOT);

        // R2: invalid code ignored
        send_len(4'b0101);
        measure(len, lit);
        check(len == 11 * SLOT, "R2 invalid length ignored", len, 11 * SLOT);
        check(lit == 11 * 10 * TD, "R2 display kept on", lit, 11 * 10 * TD);

        // R6: change forces off at once
        while (grid_en == 0) @(negedge clk);
        send_len(4'b1111);
        check(grid_en == 0 && seg_en == 0, "R6 off next clock", grid_en, 0);
        wait_end();
        // R8: dark cycle still runs
        measure(len, lit);
        check(lit == 0, "R8 dark while off", lit, 0);
        check(len == 16 * SLOT, "R8 scan continues", len, 16 * SLOT);

        // R7: same code keeps display on
        send_ctl(2, 1'b1);
        wait_end();
        send_len(4'b1111);
        measure(len, lit);
        check(lit == 16 * 4 * TD, "R7 same length keeps on", lit, 16 * 4 * TD);

        // R9: brightness change waits for boundary
        wait_end();
        repeat (SLOT + 2) @(negedge clk);
        send_ctl(7, 1'b1);
        while (grid_en == 0) @(negedge clk);
        len = 0;
        while (grid_en != 0) begin len++; @(negedge clk); end
        check(len == 4 * TD, "R9 width held until boundary", len, 4 * TD);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule